// File: doc/BRIEF.md
# UART CPU Data Port and Interrupt Mask

This block is the processor-facing front end of an enhanced UART. One register offset carries the character data. A processor write there feeds the transmit path, and a processor read there drains the receive path. Each path is a single holding register while queuing is off, and a 16-entry first-in-first-out queue while queuing is on. A separate DMA port reaches the same two paths. It ignores the register bank the processor has selected. Processor register accesses count only while bank 0 is selected.

An 8-bit interrupt mask register sits next to the data offset. It gates a set of event sources into one interrupt line. The upper four mask bits can hold a 1 only while extended mode is active. Dropping out of extended mode clears them. Two of the event sources are computed inside the block from queue occupancy and programmable thresholds. The others arrive from the neighbouring serial, line-status and timer logic. The serial shifter removes transmit bytes through a take strobe and delivers received bytes through a load strobe.

Top module: `uart_data_front`

## Requirements
- R1: After reset the mask register reads 0x00, both paths are empty (`tx_valid` low), `tx_ovr` is low and `irq` is low.
- R2: A processor write to offset 0 in bank 0 adds a byte to the transmit path. The path holds 1 byte with queuing off and DEPTH bytes with queuing on. A write to a full path is dropped and sets `tx_ovr`, which stays set until the next flush.
- R3: A processor read at offset 0 in bank 0 returns the oldest received byte and removes it. A read of an empty receive path returns the last byte removed and leaves the path unchanged.
- R4: Both paths deliver bytes in the order they were added.
- R5: DMA writes (`dma_wr`) and DMA reads (`dma_rd`) reach the data paths whatever `bank` holds. Processor accesses with `bank` other than 0 have no effect on the paths.
- R6: The mask register sits at offset 1 of bank 0 and reads back what was written. Bits 7:4 take a written 1 only while `ext_mode` is high. They read 0 whenever `ext_mode` is low, including after a drop out of extended mode.
- R7: `irq` is the OR, over all eight bits, of event AND mask bit. Bit 0 is receive-high. Bit 1 is transmit-low. Bit 2 is `ls_evt`, ORed with `tx_halt_evt` only when `uart_mode` is low. Bits 7:3 are `ext_evt[4:0]`.
- R8: With queuing on, receive-high means the receive count is at least `rx_thr` and above zero, and transmit-low means the transmit count is at most `tx_thr`. With queuing off, receive-high means the holding register is full and transmit-low means it is empty.
- R9: When `fifo_en` goes from 0 to 1, both paths are emptied, `tx_ovr` is cleared and the last-read byte is cleared to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bank | input | BW | Currently selected register bank |
| cpu_sel | input | 1 | Processor access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Register offset |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Processor read data |
| dma_wr | input | 1 | DMA write into the transmit path |
| dma_wdata | input | DW | DMA write data |
| dma_rd | input | 1 | DMA read from the receive path |
| dma_rdata | output | DW | DMA read data |
| fifo_en | input | 1 | Queuing on |
| ext_mode | input | 1 | Extended mode active |
| uart_mode | input | 1 | Plain UART operation (halted event masked from bit 2) |
| rx_thr | input | CW | Receive-high threshold |
| tx_thr | input | CW | Transmit-low threshold |
| tx_take | input | 1 | Shifter removes the transmit head |
| tx_data | output | DW | Transmit head byte |
| tx_valid | output | 1 | Transmit path not empty |
| rx_load | input | 1 | Shifter adds a received byte |
| rx_byte | input | DW | Received byte |
| ls_evt | input | 1 | Link status event |
| tx_halt_evt | input | 1 | Transmitter halted event |
| ext_evt | input | 5 | Events for mask bits 7:3 |
| tx_ovr | output | 1 | Sticky transmit overrun |
| irq | output | 1 | Combined interrupt |

## Verification
Read data on `cpu_rdata`, `dma_rdata` and `tx_data` is combinational from the stored state. It is valid in the same cycle as the read or take strobe, and the removal takes effect at the closing edge. The monitor therefore compares these outputs half a cycle after the strobe is driven, before that edge. Counts, `tx_valid`, `tx_ovr` and the mask register change at the edge that ends an access and are checked one time step after it. `irq` follows event inputs in the same cycle and follows mask or count changes one edge later, and the bench samples it right after the edge that changed its inputs.

// File: rtl/uart_data_front.sv
module uart_data_front #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int BW    = 3,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] bank,
  input  logic          cpu_sel,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          dma_wr,
  input  logic [DW-1:0] dma_wdata,
  input  logic          dma_rd,
  output logic [DW-1:0] dma_rdata,
  input  logic          fifo_en,
  input  logic          ext_mode,
  input  logic          uart_mode,
  input  logic [CW-1:0] rx_thr,
  input  logic [CW-1:0] tx_thr,
  input  logic          tx_take,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          rx_load,
  input  logic [DW-1:0] rx_byte,
  input  logic          ls_evt,
  input  logic          tx_halt_evt,
  input  logic [4:0]    ext_evt,
  output logic          tx_ovr,
  output logic          irq
);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [7:0]    ier;
  logic [DW-1:0] rx_last;
  logic          fen_q;

  wire in_b0    = (bank == '0);
  wire reg_hit  = cpu_sel && in_b0;
  wire data_hit = reg_hit && (cpu_addr == AW'(0));
  wire ier_wr   = reg_hit && cpu_wr && (cpu_addr == AW'(1));
  wire cpu_txw  = data_hit && cpu_wr;
  wire cpu_rxr  = data_hit && !cpu_wr;

  wire          tx_wr = cpu_txw || dma_wr;
  wire [DW-1:0] tx_wd = cpu_txw ? cpu_wdata : dma_wdata;
  wire          rx_rd = cpu_rxr || dma_rd;
  wire          flush = fifo_en && !fen_q;

  wire [CW-1:0] cap     = fifo_en ? CW'(DEPTH) : CW'(1);
  wire          tx_push = tx_wr && (tx_cnt < cap);
  wire          tx_drop = tx_wr && (tx_cnt >= cap);
  wire          tx_pop  = tx_take && (tx_cnt != '0);
  wire          rx_push = rx_load && (rx_cnt < cap);
  wire          rx_pop  = rx_rd && (rx_cnt != '0);

  wire [DW-1:0] rx_view = (rx_cnt != '0) ? rx_mem[rx_rp] : rx_last;

  assign tx_data   = tx_mem[tx_rp];
  assign tx_valid  = (tx_cnt != '0);
  assign dma_rdata = rx_view;

  always_comb begin
    cpu_rdata = '0;
    if (reg_hit && !cpu_wr) begin
      if (cpu_addr == AW'(0))      cpu_rdata = rx_view;
      else if (cpu_addr == AW'(1)) cpu_rdata = DW'(ier);
    end
  end

  wire rx_hi = fifo_en ? ((rx_cnt != '0) && (rx_cnt >= rx_thr)) : (rx_cnt != '0);
  wire tx_lo = fifo_en ? (tx_cnt <= tx_thr) : (tx_cnt == '0);
  wire [7:0] evt = {ext_evt, ls_evt | (!uart_mode & tx_halt_evt), tx_lo, rx_hi};
  assign irq = |(ier & evt);

  always_ff @(posedge clk) begin
    if (tx_push && !flush) tx_mem[tx_wp] <= tx_wd;
    if (rx_push && !flush) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      tx_ovr <= 1'b0; rx_last <= '0; fen_q <= 1'b0;
    end else begin
      fen_q <= fifo_en;
      if (flush) begin
        tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
        rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
        tx_ovr <= 1'b0; rx_last <= '0;
      end else begin
        if (tx_push) tx_wp <= tx_wp + 1'b1;
        if (tx_pop)  tx_rp <= tx_rp + 1'b1;
        tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
        if (tx_drop) tx_ovr <= 1'b1;
        if (rx_push) rx_wp <= rx_wp + 1'b1;
        if (rx_pop) begin
          rx_rp   <= rx_rp + 1'b1;
          rx_last <= rx_mem[rx_rp];
        end
        rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ier <= '0;
    else begin
      ier[3:0] <= ier_wr ? cpu_wdata[3:0] : ier[3:0];
      ier[7:4] <= !ext_mode ? 4'b0 : (ier_wr ? cpu_wdata[7:4] : ier[7:4]);
    end
  end

endmodule

module uart_data_front_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_mode,
  input logic          fifo_en,
  input logic          fen_q,
  input logic [7:0]    ier,
  input logic          irq,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_ovr,
  input logic          rx_rd,
  input logic          rx_load
);

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH)); // R2

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovr && !(fifo_en && !fen_q)) |=> tx_ovr); // R2

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_cnt == '0 && !rx_load) |=> (rx_cnt == '0)); // R3

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |=> (ier[7:4] == 4'b0)); // R6

  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 8'h00) |-> !irq); // R7

  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !fen_q) |=> (tx_cnt == '0 && rx_cnt == '0 && !tx_ovr)); // R9

endmodule

bind uart_data_front uart_data_front_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .fifo_en(fifo_en),
  .fen_q(fen_q), .ier(ier), .irq(irq), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_ovr(tx_ovr), .rx_rd(rx_rd), .rx_load(rx_load)
);

// File: tb/uart_data_front_tb.sv
module uart_data_front_tb_top;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bank = '0;
  logic cpu_sel = 0, cpu_wr = 0;
  logic [2:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata, dma_wdata = '0, dma_rdata, tx_data, rx_byte = '0;
  logic dma_wr = 0, dma_rd = 0, fifo_en = 0, ext_mode = 0, uart_mode = 1;
  logic [CW-1:0] rx_thr = CW'(4), tx_thr = CW'(2);
  logic tx_take = 0, tx_valid, rx_load = 0, ls_evt = 0, tx_halt_evt = 0;
  logic [4:0] ext_evt = '0;
  logic tx_ovr, irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #4 clk = ~clk;

  uart_data_front #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bank(bank), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dma_wr(dma_wr), .dma_wdata(dma_wdata), .dma_rd(dma_rd), .dma_rdata(dma_rdata),
    .fifo_en(fifo_en), .ext_mode(ext_mode), .uart_mode(uart_mode),
    .rx_thr(rx_thr), .tx_thr(tx_thr), .tx_take(tx_take), .tx_data(tx_data),
    .tx_valid(tx_valid), .rx_load(rx_load), .rx_byte(rx_byte), .ls_evt(ls_evt),
    .tx_halt_evt(tx_halt_evt), .ext_evt(ext_evt), .tx_ovr(tx_ovr), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (tx_take) begin
      if (txq.size() == 0) check("R4 tx unexpected", 1, 0);
      else check("R2/R4 tx order", tx_data, txq.pop_front());
    end
    if (cpu_sel && !cpu_wr && cpu_addr == 0 && bank == 0) begin
      if (rxq.size() == 0) check("R3 rx unexpected", 1, 0);
      else check("R3/R4 cpu rx", cpu_rdata, rxq.pop_front());
    end
    if (dma_rd) begin
      if (rxq.size() == 0) check("R5 dma unexpected", 1, 0);
      else check("R5 dma rx", dma_rdata, rxq.pop_front());
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic cpu_write(logic [2:0] a, logic [7:0] d);
    cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    tick(); cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic cpu_read();
    cpu_sel = 1; cpu_wr = 0; cpu_addr = 0;
    tick(); cpu_sel = 0;
  endtask

  task automatic ier_check(string req, logic [7:0] exp);
    cpu_sel = 1; cpu_wr = 0; cpu_addr = 1; #1;
    check(req, cpu_rdata, exp);
    tick(); cpu_sel = 0;
  endtask

  task automatic take();  tx_take = 1; tick(); tx_take = 0; endtask
  task automatic load(logic [7:0] d); rx_load = 1; rx_byte = d; tick(); rx_load = 0; endtask

  initial begin
    #(8 * 20000);
    check("watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; tick();
    // R1 reset state
    check("R1 tx_valid", tx_valid, 0);
    check("R1 tx_ovr", tx_ovr, 0);
    check("R1 irq", irq, 0);
    ier_check("R1 mask", 8'h00);

    // R2 holding register (queuing off)
    cpu_write(0, 8'hA1); txq.push_back(8'hA1);
    check("R2 holding full", tx_valid, 1);
    cpu_write(0, 8'hB2);
    check("R2 overrun", tx_ovr, 1);
    take();
    check("R2 holding empty", tx_valid, 0);
    check("R2 overrun sticky", tx_ovr, 1);

    // R3 receive holding, empty read returns last
    load(8'h11); load(8'h22);
    rxq.push_back(8'h11); cpu_read();
    rxq.push_back(8'h11); cpu_read();

    // R9 flush on enabling queuing
    cpu_write(0, 8'hC3);
    load(8'h33);
    fifo_en = 1; tick();
    check("R9 tx flushed", tx_valid, 0);
    check("R9 ovr cleared", tx_ovr, 0);
    rxq.push_back(8'h00); cpu_read();

    // R2/R4 full queue
    for (int i = 0; i < DEPTH; i++) begin
      cpu_write(0, 8'h40 + 8'(i)); txq.push_back(8'h40 + 8'(i));
    end
    check("R2 no overrun yet", tx_ovr, 0);
    cpu_write(0, 8'hEE);
    check("R2 full overrun", tx_ovr, 1);
    for (int i = 0; i < DEPTH; i++) take();
    check("R4 tx drained", tx_valid, 0);
    for (int i = 0; i < 5; i++) load(8'h80 + 8'(i));
    for (int i = 0; i < 5; i++) begin rxq.push_back(8'h80 + 8'(i)); cpu_read(); end

    // R5 DMA bypasses bank, CPU ignored outside bank 0
    bank = 3;
    cpu_write(0, 8'h55);
    check("R5 cpu write other bank", tx_valid, 0);
    dma_wr = 1; dma_wdata = 8'h66; tick(); dma_wr = 0; txq.push_back(8'h66);
    check("R5 dma write", tx_valid, 1);
    take();
    load(8'h77);
    cpu_read();
    rxq.push_back(8'h77); dma_rd = 1; tick(); dma_rd = 0;
    load(8'h78);
    rxq.push_back(8'h78); dma_rd = 1; tick(); dma_rd = 0;
    bank = 0;

    // R6 mask upper bits gated by extended mode
    cpu_write(1, 8'hFF);
    ier_check("R6 non-ext write", 8'h0F);
    ext_mode = 1; tick();
    cpu_write(1, 8'hFF);
    ier_check("R6 ext write", 8'hFF);
    ext_mode = 0; tick();
    ier_check("R6 leave ext", 8'h0F);

    // R7/R8 interrupt combination and thresholds
    cpu_write(1, 8'h01);
    check("R7 rx-high masked only", irq, 0);
    load(1); load(2); load(3);
    check("R8 below rx thr", irq, 0);
    load(4);
    check("R8 at rx thr", irq, 1);
    for (int i = 1; i <= 4; i++) begin rxq.push_back(8'(i)); cpu_read(); end
    check("R8 rx drained", irq, 0);
    cpu_write(1, 8'h02);
    check("R8 tx low empty", irq, 1);
    for (int i = 0; i < 3; i++) begin cpu_write(0, 8'h90 + 8'(i)); txq.push_back(8'h90 + 8'(i)); end
    check("R8 tx above thr", irq, 0);
    take();
    check("R8 tx at thr", irq, 1);
    take(); take();
    cpu_write(1, 8'h04);
    tx_halt_evt = 1; #1;
    check("R7 halt masked in uart mode", irq, 0);
    uart_mode = 0; #1;
    check("R7 halt in other mode", irq, 1);
    tx_halt_evt = 0; ls_evt = 1; #1;
    check("R7 link status", irq, 1);
    ls_evt = 0; uart_mode = 1;
    ext_mode = 1; tick();
    cpu_write(1, 8'h80);
    ext_evt = 5'b10000; #1;
    check("R7 bit7 event", irq, 1);
    ext_mode = 0; tick();
    check("R6 upper cleared drops irq", irq, 0);
    ext_evt = '0;

    check("R4 queues consumed", txq.size() + rxq.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule